// File: doc/BRIEF.md
# Comparator-Driven Clock Phase Edge Search

This block tunes a 6-bit phase setting for an external clock phase shifter until a single-bit phase comparator shows a clean, repeatable falling transition. It moves the phase one step at a time. Each step writes the setting, waits a settle interval, flips a load-change strobe that tells the shifter to take the new value, and samples the comparator one clock later. A first search locates a 1-to-0 change. A sequence of confirmation passes then walks forward past it, back over it, and back again to well before it, and rejects edges that prove false or noisy. After that the edge is searched for again, and the phase finally settles one step below the last value written.

The controller is launched with a start pulse and an initial phase. It reports success or failure and the number of adjustment steps it took. Two budgets bound its effort: a cap on total adjustment steps and a cap on the number of attempts. An attempt is abandoned, and a new one begins, whenever a confirmation pass fails.

Top module: `phase_edge_search`

## Requirements
- R1: After reset, phase_o is 0, load_o is 0, done_o and fail_o are low, and adj_cnt_o is 0.
- R2: Phase arithmetic wraps modulo 64 in both directions: 63 plus one gives 0, and 0 minus one gives 63.
- R3: During a search pass each step loads the current candidate. A comparator reading of 1 makes the next candidate one higher, and a reading of 0 makes it one lower. The pass ends only when the previous reading was 1 and the new reading is 0. The first "previous" reading of a run is cmp_in sampled at the start pulse.
- R4: After the first edge, the phase is raised one step at a time for as long as the latest reading is 0, up to FWD_STEPS (5) steps. Fewer than FWD_STEPS steps abandons the attempt.
- R5: The phase is then lowered one step at a time for as long as the latest reading is 0, up to BACK_STEPS (3) steps. Fewer than BACK_STEPS steps abandons the attempt.
- R6: The phase is then lowered exactly RETREAT_STEPS (5) more times. If the last reading is 0, the attempt is abandoned. If it is 1, a second search pass (same rules as R3) follows.
- R7: Every step writes phase_o and holds it for at least SETTLE_CYC clocks before load_o flips. cmp_in is sampled on the clock after the flip, and adj_cnt_o rises by exactly one per step.
- R8: When adj_cnt_o reaches MAX_ADJ, fail_o rises at once with adj_cnt_o equal to MAX_ADJ, and phase_o keeps the last value written.
- R9: When MAX_TRY attempts have all been abandoned, fail_o rises without any further load.
- R10: On success, the phase one below the last value written in the second search pass is loaded with one more load_o flip. This flip is not counted in adj_cnt_o. done_o then rises, and all outputs hold until the next start.
- R11: start is accepted only while idle. Accepting it clears done_o, fail_o and adj_cnt_o and loads init_phase. A start during a run has no effect, and done_o and fail_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request to begin a run while idle |
| init_phase | input | PHASE_W | Phase value a run begins from |
| cmp_in | input | 1 | Phase comparator reading |
| phase_o | output | PHASE_W | Phase setting driven to the shifter |
| load_o | output | 1 | Load-change strobe, flips once per load |
| done_o | output | 1 | Run ended with an aligned phase |
| fail_o | output | 1 | Run ended on a step or attempt budget |
| adj_cnt_o | output | clog2(MAX_ADJ+1) | Adjustment steps taken in this run |

## Verification
A start request can coincide with a step that is still in flight: the controller is between a write and its sample, and a new run must not begin. The bench provokes this during a run that only ends at the adjustment budget. It pulses start with a different initial phase while the comparator model keeps reading 1. The scoreboard must then see the unchanged sequence of loaded phases, and fail_o must rise with the count at the budget. A second overlap is the step budget running out on the same sample that completes an edge. The design gives failure priority there, and the bench's reference model encodes the same rule.

// File: rtl/phs_pkg.sv
// Shared types for the phase edge search controller.
// Assumes: nothing beyond IEEE 1800-2017 enum support.
package phs_pkg;

    // Per-step sequencing of one phase adjustment.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PLAN,
        ST_WRITE,
        ST_WAIT,
        ST_TOGGLE,
        ST_SAMPLE
    } seq_state_t;

    // Which pass of the edge validation is running.
    typedef enum logic [2:0] {
        SG_SEEK,
        SG_FWD,
        SG_BACK,
        SG_RETREAT,
        SG_RESEEK,
        SG_FINAL
    } stage_t;

endpackage

// File: rtl/phs_settle_timer.sv
// Settle interval timer: after arm, expired_o stays low until SETTLE_CYC
// further clocks have passed, then reads high until re-armed.
// Assumes: SETTLE_CYC >= 1.
module phs_settle_timer #(
    parameter int SETTLE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic expired_o
);
    localparam int TW = $clog2(SETTLE_CYC + 1);

    logic [TW-1:0] remain;

    // Load on arm, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (arm)
            remain <= TW'(SETTLE_CYC);
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign expired_o = (remain == '0);
endmodule

// File: rtl/phs_adj_counter.sv
// Adjustment step counter with a flag for the last step before the budget.
// Assumes: MAX_ADJ >= 1 and the owner stops incrementing once last_o was used.
module phs_adj_counter #(
    parameter int MAX_ADJ = 65535,
    parameter int CW      = $clog2(MAX_ADJ + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt_o,
    output logic          last_o
);
    // Clear on a new run, count one per adjustment step.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt_o <= '0;
        else if (inc)
            cnt_o <= cnt_o + 1'b1;
    end

    assign last_o = (cnt_o == CW'(MAX_ADJ - 1));
endmodule

// File: rtl/phase_edge_search.sv
// Phase edge search controller. Steps a phase setting, waits, flips the load
// strobe, samples a comparator, and validates a falling comparator edge with
// forward, backward and retreat passes before a final re-search.
// Assumes: cmp_in reflects the phase loaded by the most recent load_o flip
// one clock after that flip; start is a single-cycle pulse.
module phase_edge_search
    import phs_pkg::*;
#(
    parameter int PHASE_W       = 6,
    parameter int SETTLE_CYC    = 2,
    parameter int MAX_ADJ       = 65535,
    parameter int MAX_TRY       = 10,
    parameter int FWD_STEPS     = 5,
    parameter int BACK_STEPS    = 3,
    parameter int RETREAT_STEPS = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [PHASE_W-1:0]           init_phase,
    input  logic                         cmp_in,
    output logic [PHASE_W-1:0]           phase_o,
    output logic                         load_o,
    output logic                         done_o,
    output logic                         fail_o,
    output logic [$clog2(MAX_ADJ+1)-1:0] adj_cnt_o
);
    localparam int CW      = $clog2(MAX_ADJ + 1);
    localparam int MAXSTEP = (FWD_STEPS > BACK_STEPS) ?
                             ((FWD_STEPS > RETREAT_STEPS) ? FWD_STEPS : RETREAT_STEPS) :
                             ((BACK_STEPS > RETREAT_STEPS) ? BACK_STEPS : RETREAT_STEPS);
    localparam int SW      = $clog2(MAXSTEP + 1);
    localparam int TRW     = $clog2(MAX_TRY + 1);

    seq_state_t         st;
    stage_t             sg;
    logic [PHASE_W-1:0] cand;
    logic               cval;
    logic [SW-1:0]      step_cnt;
    logic [TRW-1:0]     tries;
    logic               settle_done;
    logic               adj_last;
    logic               retry_last;

    assign retry_last = (tries == TRW'(MAX_TRY - 1));

    phs_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (st == ST_WRITE),
        .expired_o (settle_done)
    );

    phs_adj_counter #(.MAX_ADJ(MAX_ADJ), .CW(CW)) u_adj (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (st == ST_IDLE && start),
        .inc    (st == ST_SAMPLE),
        .cnt_o  (adj_cnt_o),
        .last_o (adj_last)
    );

    // Sequencer: chooses the next step, runs write/settle/load/sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            sg       <= SG_SEEK;
            cand     <= '0;
            cval     <= 1'b0;
            step_cnt <= '0;
            tries    <= '0;
            phase_o  <= '0;
            load_o   <= 1'b0;
            done_o   <= 1'b0;
            fail_o   <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        cand     <= init_phase;
                        cval     <= cmp_in;
                        sg       <= SG_SEEK;
                        step_cnt <= '0;
                        tries    <= '0;
                        done_o   <= 1'b0;
                        fail_o   <= 1'b0;
                        st       <= ST_PLAN;
                    end
                end
                ST_PLAN: begin
                    case (sg)
                        SG_FWD: begin
                            if (step_cnt < SW'(FWD_STEPS) && !cval) begin
                                cand     <= cand + 1'b1;
                                step_cnt <= step_cnt + 1'b1;
                                st       <= ST_WRITE;
                            end else if (step_cnt == SW'(FWD_STEPS)) begin
                                sg       <= SG_BACK;
                                step_cnt <= '0;
                            end else if (retry_last) begin
                                fail_o <= 1'b1;
                                st     <= ST_IDLE;
                            end else begin
                                tries    <= tries + 1'b1;
                                sg       <= SG_SEEK;
                                step_cnt <= '0;
                            end
                        end
                        SG_BACK: begin
                            if (step_cnt < SW'(BACK_STEPS) && !cval) begin
                                cand     <= cand - 1'b1;
                                step_cnt <= step_cnt + 1'b1;
                                st       <= ST_WRITE;
                            end else if (step_cnt == SW'(BACK_STEPS)) begin
                                sg       <= SG_RETREAT;
                                step_cnt <= '0;
                            end else if (retry_last) begin
                                fail_o <= 1'b1;
                                st     <= ST_IDLE;
                            end else begin
                                tries    <= tries + 1'b1;
                                sg       <= SG_SEEK;
                                step_cnt <= '0;
                            end
                        end
                        SG_RETREAT: begin
                            if (step_cnt < SW'(RETREAT_STEPS)) begin
                                cand     <= cand - 1'b1;
                                step_cnt <= step_cnt + 1'b1;
                                st       <= ST_WRITE;
                            end else if (cval) begin
                                sg <= SG_RESEEK;
                            end else if (retry_last) begin
                                fail_o <= 1'b1;
                                st     <= ST_IDLE;
                            end else begin
                                tries    <= tries + 1'b1;
                                sg       <= SG_SEEK;
                                step_cnt <= '0;
                            end
                        end
                        default: st <= ST_WRITE;
                    endcase
                end
                ST_WRITE: begin
                    phase_o <= cand;
                    st      <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (settle_done)
                        st <= ST_TOGGLE;
                end
                ST_TOGGLE: begin
                    load_o <= ~load_o;
                    if (sg == SG_FINAL) begin
                        done_o <= 1'b1;
                        st     <= ST_IDLE;
                    end else begin
                        st <= ST_SAMPLE;
                    end
                end
                ST_SAMPLE: begin
                    cval <= cmp_in;
                    if (adj_last) begin
                        fail_o <= 1'b1;
                        st     <= ST_IDLE;
                    end else begin
                        st <= ST_PLAN;
                        if (sg == SG_SEEK || sg == SG_RESEEK) begin
                            cand <= cmp_in ? cand + 1'b1 : cand - 1'b1;
                            if (cval && !cmp_in) begin
                                sg       <= (sg == SG_SEEK) ? SG_FWD : SG_FINAL;
                                step_cnt <= '0;
                            end
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/phase_edge_search_chk.sv
// Property checker for the phase edge search controller, bound to the top.
// Assumes: connected to the top-level ports of phase_edge_search.
module phase_edge_search_chk #(
    parameter int PHASE_W    = 6,
    parameter int SETTLE_CYC = 2,
    parameter int MAX_ADJ    = 65535,
    parameter int CW         = $clog2(MAX_ADJ + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [PHASE_W-1:0] phase_o,
    input logic               load_o,
    input logic               done_o,
    input logic               fail_o,
    input logic [CW-1:0]      adj_cnt_o
);
    localparam int HW = $clog2(SETTLE_CYC + 2) + 1;

    logic [PHASE_W-1:0] ph_q;
    logic [HW-1:0]      hold_cnt;

    // Count clocks for which phase_o has not changed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q     <= '0;
            hold_cnt <= '0;
        end else begin
            ph_q <= phase_o;
            if (phase_o != ph_q)
                hold_cnt <= '0;
            else if (hold_cnt != '1)
                hold_cnt <= hold_cnt + 1'b1;
        end
    end

    // R11
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fail_o));

    // R8
    adj_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adj_cnt_o <= CW'(MAX_ADJ));

    // R7
    settle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_o != $past(load_o)) |-> (hold_cnt >= HW'(SETTLE_CYC)));

    // R7
    adj_unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adj_cnt_o != $past(adj_cnt_o)) |->
            (adj_cnt_o == $past(adj_cnt_o) + 1'b1 || adj_cnt_o == '0));

    // R10
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start) |=> (done_o && $stable(phase_o) && $stable(load_o)));
endmodule

bind phase_edge_search phase_edge_search_chk #(
    .PHASE_W    (PHASE_W),
    .SETTLE_CYC (SETTLE_CYC),
    .MAX_ADJ    (MAX_ADJ)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .phase_o   (phase_o),
    .load_o    (load_o),
    .done_o    (done_o),
    .fail_o    (fail_o),
    .adj_cnt_o (adj_cnt_o)
);

// File: tb/phase_edge_search_test.sv
`timescale 1ns/1ps
module phase_edge_search_test;
    localparam int PW     = 6;
    localparam int SETTLE = 2;
    localparam int MAXA   = 300;
    localparam int MAXT   = 10;
    localparam int CW     = $clog2(MAXA + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [PW-1:0] init_phase = '0;
    logic          cmp_r = 1'b0;
    logic [PW-1:0] phase_o;
    logic          load_o;
    logic          done_o;
    logic          fail_o;
    logic [CW-1:0] adj_cnt_o;

    int checks = 0, errs = 0, mon_checks = 0, mon_errs = 0;
    int kind = 0, noise_idx = 0, tog = 0, tog_base = 0, hold_n = 0;
    logic [PW-1:0] base = '0, shadow = '0, ph_seen = '0;
    logic          load_seen = 1'b0;
    int            exp_q[$];

    always #10 clk = ~clk;

    phase_edge_search #(.PHASE_W(PW), .SETTLE_CYC(SETTLE), .MAX_ADJ(MAXA),
                        .MAX_TRY(MAXT)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .init_phase(init_phase),
        .cmp_in(cmp_r), .phase_o(phase_o), .load_o(load_o), .done_o(done_o),
        .fail_o(fail_o), .adj_cnt_o(adj_cnt_o));

    // Comparator model: kind 0 square (1 for 32 phases from base), 1 square
    // with a 0 spike at base+20, 2 stuck at 1, 3 equals phase bit 0.
    function automatic logic cmpf(input logic [PW-1:0] ph, input int tg);
        logic [PW-1:0] off;
        logic v;
        off = ph - base;
        case (kind)
            0: v = (off < 6'd32);
            1: v = (off < 6'd32) && (off != 6'd20);
            2: v = 1'b1;
            default: v = ph[0];
        endcase
        if (noise_idx != 0 && tg == noise_idx) v = ~v;
        return v;
    endfunction

    // Monitor: shifter model plus scoreboard pop on every load flip.
    always @(negedge clk) begin
        if (load_o !== load_seen) begin
            load_seen = load_o;
            tog++;
            shadow = phase_o;
            mon_checks += 2;
            if (exp_q.size() == 0) begin
                mon_errs++;
                $display("FAIL R7: unexpected load of phase %0d, expected no load", phase_o);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (int'(phase_o) != e) begin
                    mon_errs++;
                    $display("FAIL R3: loaded phase %0d, expected %0d", phase_o, e);
                end
            end
            if (hold_n < SETTLE) begin
                mon_errs++;
                $display("FAIL R7: phase held %0d clocks before load, expected >= %0d", hold_n, SETTLE);
            end
        end
        if (phase_o !== ph_seen) begin
            ph_seen = phase_o;
            hold_n = 0;
        end else begin
            hold_n++;
        end
        cmp_r = cmpf(shadow, tog - tog_base);
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic mstep(input logic [PW-1:0] ph, inout int tg, inout int a, output logic c);
        tg++;
        exp_q.push_back(int'(ph));
        c = cmpf(ph, tg);
        a++;
    endtask

    // Reference model of the requirements: fills the expected load queue.
    task automatic model(input logic [PW-1:0] init, output int fph, output int fadj,
                         output bit fdone, output bit ffail);
        logic [PW-1:0] p, last;
        logic cv, pv, c;
        int a, tries, tg, n;
        bit restart;
        p = init; last = shadow; cv = cmpf(shadow, 0);
        a = 0; tries = 0; tg = 0; fdone = 0; ffail = 0;
        while (1) begin
            restart = 0;
            do begin
                pv = cv; mstep(p, tg, a, c); cv = c; last = p;
                p = c ? p + 1'b1 : p - 1'b1;
            end while (a < MAXA && !(pv && !c));
            if (a >= MAXA) begin ffail = 1; break; end
            n = 0;
            while (n < 5 && !cv && a < MAXA) begin
                p = p + 1'b1; mstep(p, tg, a, c); cv = c; last = p; n++;
            end
            if (a >= MAXA) begin ffail = 1; break; end
            if (n != 5) restart = 1;
            if (!restart) begin
                n = 0;
                while (n < 3 && !cv && a < MAXA) begin
                    p = p - 1'b1; mstep(p, tg, a, c); cv = c; last = p; n++;
                end
                if (a >= MAXA) begin ffail = 1; break; end
                if (n != 3) restart = 1;
            end
            if (!restart) begin
                n = 0;
                while (n < 5 && a < MAXA) begin
                    p = p - 1'b1; mstep(p, tg, a, c); cv = c; last = p; n++;
                end
                if (a >= MAXA) begin ffail = 1; break; end
                if (!cv) restart = 1;
            end
            if (!restart) begin
                do begin
                    pv = cv; mstep(p, tg, a, c); cv = c; last = p;
                    p = c ? p + 1'b1 : p - 1'b1;
                end while (a < MAXA && !(pv && !c));
                if (a >= MAXA) begin ffail = 1; break; end
                exp_q.push_back(int'(p));
                last = p; fdone = 1;
                break;
            end
            if (tries == MAXT - 1) begin ffail = 1; break; end
            tries++;
        end
        fph = int'(last); fadj = a;
    endtask

    // Driver: configures the comparator, predicts, runs, compares the result.
    task automatic run_case(input int k, input logic [PW-1:0] b, input int nz,
                            input logic [PW-1:0] init, input string tag, input bit poke);
        int fph, fadj;
        bit fdone, ffail;
        @(negedge clk);
        kind = k; base = b; noise_idx = nz; tog_base = tog;
        model(init, fph, fadj, fdone, ffail);
        @(negedge clk);
        init_phase = init; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (60) @(negedge clk);
            init_phase = init + 6'd9; start = 1'b1;   // R11: ignored while busy
            @(negedge clk);
            start = 1'b0;
        end
        while (!(done_o || fail_o)) @(negedge clk);
        @(negedge clk);
        chk(done_o == fdone, {tag, " done"}, done_o, fdone);
        chk(fail_o == ffail, {tag, " fail"}, fail_o, ffail);
        chk(int'(phase_o) == fph, {tag, " phase"}, phase_o, fph);
        chk(int'(adj_cnt_o) == fadj, {tag, " count"}, adj_cnt_o, fadj);
        chk(exp_q.size() == 0, {tag, " loads left"}, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(phase_o == '0, "R1 phase", phase_o, 0);
        chk(load_o == 1'b0, "R1 load", load_o, 0);
        chk(!done_o && !fail_o, "R1 flags", {done_o, fail_o}, 0);
        chk(adj_cnt_o == '0, "R1 count", adj_cnt_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3 R10: plain square, edge between 31 and 32
        run_case(0, 6'd0, 0, 6'd28, "R3", 1'b0);
        chk(phase_o == 6'd31, "R10 final phase", phase_o, 31);
        begin
            logic [PW-1:0] ph_keep;
            logic ld_keep;
            ph_keep = phase_o; ld_keep = load_o;
            repeat (20) @(negedge clk);
            chk(done_o && phase_o == ph_keep && load_o == ld_keep, "R10 hold", phase_o, ph_keep);
        end
        // R2 upward wrap 63 -> 0, edge between 7 and 8
        run_case(0, 6'd40, 0, 6'd60, "R2 up", 1'b0);
        chk(phase_o == 6'd7, "R2 up final", phase_o, 7);
        // R2 downward wrap 0 -> 63, edge between 47 and 48
        run_case(0, 6'd16, 0, 6'd2, "R2 down", 1'b0);
        chk(phase_o == 6'd47, "R2 down final", phase_o, 47);
        // R4 spike makes a false edge
        run_case(1, 6'd0, 0, 6'd15, "R4", 1'b0);
        chk(done_o && phase_o == 6'd31, "R4 final", phase_o, 31);
        // R5 one noisy reading during the backward pass
        run_case(0, 6'd0, 12, 6'd28, "R5", 1'b0);
        chk(done_o && adj_cnt_o > 6'd26, "R5 retried", adj_cnt_o, 27);
        // R6 retreat ends on a 0 reading
        run_case(0, 6'd0, 18, 6'd28, "R6", 1'b0);
        chk(done_o && phase_o == 6'd31, "R6 final", phase_o, 31);
        // R8 R11 stuck comparator, start poked mid-run
        run_case(2, 6'd0, 0, 6'd5, "R8", 1'b1);
        chk(fail_o && int'(adj_cnt_o) == MAXA, "R8 cap", adj_cnt_o, MAXA);
        // R9 alternating comparator exhausts attempts
        run_case(3, 6'd0, 0, 6'd0, "R9", 1'b0);
        chk(fail_o && int'(adj_cnt_o) < MAXA, "R9 below cap", adj_cnt_o, MAXA - 1);
        // R11 new start clears flags
        run_case(0, 6'd8, 0, 6'd20, "R11", 1'b0);
        chk(done_o && !fail_o, "R11 flags", fail_o, 0);

        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors",
                 checks + mon_checks, errs + mon_errs);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL R11: watchdog expired, actual hung, expected completion");
        $display("Simulation finished: %0d checks, %0d errors",
                 checks + mon_checks + 1, errs + mon_errs + 1);
        $finish;
    end
endmodule